// File: doc/BRIEF.md
# Load-Store Queue with Store-to-Load Forwarding

This block keeps the memory operations of an out-of-order core in a circular queue, one entry per operation, in the order the front end issues them. An entry is allocated at issue and marked as a load or a store. The address unit and the store-data path fill in the entry later, by index. A load is started by a request that names its entry. The queue then looks at every store older than that load. It either forwards the value of the youngest older store to the same address, or stalls because the outcome cannot yet be known, or reads a combinational data-memory port. The result returns one cycle later.

Stores never touch memory early. A store writes the data-memory port only in the cycle it retires from the head of the queue, and retiring happens only when the core asks for it and the head entry is ready. A flush input empties the queue, so memory keeps exactly the state of the operations already retired. The queue depth, the address width and the data width are parameters. A parameter can also turn forwarding off, in which case a matching store makes the load wait instead.

Top module: `memq_lsq`

## Requirements
- R1: After reset the queue is empty: alloc_rdy_o is 1, alloc_idx_o is 0, and res_vld_o, res_stall_o, retire_o and mem_we_o are 0.
- R2: Each accepted allocation takes the entry shown on alloc_idx_o, and the next allocation gets that index plus one, modulo DEPTH. When DEPTH entries are held, alloc_rdy_o is 0 and an allocation request is dropped without moving alloc_idx_o.
- R3: A load request whose older stores all have known addresses, none of them equal to the load address, presents the load address on mem_raddr_o. In the next cycle it gives res_vld_o=1, res_idx_o equal to the load's index, res_data_o equal to the value mem_rdata_i had in the request cycle, and res_fwd_o=0.
- R4: When one or more older stores have the load's address and the youngest of them has its data, the next cycle gives res_vld_o=1, res_fwd_o=1 and res_data_o equal to that youngest store's data.
- R5: When any older store still lacks its address, the load request gives res_stall_o=1 and res_vld_o=0 in the next cycle, and the load stays incomplete so that it can be requested again.
- R6: When the youngest older store with a matching address has no data yet, the load stalls as in R5.
- R7: Stores younger than the load never take part in its search, whatever their address.
- R8: Age is measured from the head of the queue, so the search and the allocation order stay correct when the entries wrap past index DEPTH-1 to index 0.
- R9: An address update and a data update that arrive in the same cycle as a load request are seen by that request's search.
- R10: mem_we_o is 1 only in a cycle where a store retires. mem_waddr_o and mem_wdata_o then carry that store's address and data.
- R11: retire_o is 1 only when commit_i is 1 and the head entry is ready: for a load, its result has been produced; for a store, both its address and its data are known. Otherwise the head stays and nothing is written.
- R12: flush_i discards every entry not retiring in that cycle, and drops any allocation or load result in that cycle. A retirement in the same cycle still takes place. Afterwards the queue is empty, and the next allocation index is the slot after the last retired entry.
- R13: A load request naming a free entry, a store, a load without an address or an already completed load produces neither res_vld_o nor res_stall_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| alloc_vld_i | input | 1 | Request to allocate the next entry |
| alloc_st_i | input | 1 | Allocated entry is a store (1) or a load (0) |
| alloc_rdy_o | output | 1 | Queue has a free entry |
| alloc_idx_o | output | $clog2(DEPTH) | Index the next allocation receives |
| agu_vld_i | input | 1 | Address update valid |
| agu_idx_i | input | $clog2(DEPTH) | Entry receiving the address |
| agu_addr_i | input | AW | Address value |
| std_vld_i | input | 1 | Store data update valid |
| std_idx_i | input | $clog2(DEPTH) | Store entry receiving the data |
| std_data_i | input | DW | Store data value |
| ld_req_i | input | 1 | Start the search for a load |
| ld_idx_i | input | $clog2(DEPTH) | Entry of the load to search for |
| mem_raddr_o | output | AW | Data memory read address |
| mem_rdata_i | input | DW | Data memory read value, same cycle |
| res_vld_o | output | 1 | Load result valid |
| res_idx_o | output | $clog2(DEPTH) | Entry of the load result |
| res_data_o | output | DW | Load result value |
| res_fwd_o | output | 1 | Result was taken from a store in the queue |
| res_stall_o | output | 1 | Last load request had to wait |
| commit_i | input | 1 | Request to retire the head entry |
| retire_o | output | 1 | Head entry retires this cycle |
| mem_we_o | output | 1 | Data memory write enable |
| mem_waddr_o | output | AW | Data memory write address |
| mem_wdata_o | output | DW | Data memory write value |
| flush_i | input | 1 | Discard all entries not retiring |

## Verification
The bench builds the queue with DEPTH=8, AW=8 and DW=16, with forwarding on. With eight entries, six allocate-and-retire rounds move the head near the end of the array, so a group of stores and loads can wrap from index 7 to index 0. A load at a low physical index can then be checked to forward from an older store at a high one. An 8-bit address lets the bench model the whole data memory, so every write made at retirement, and every write not made before it, can be checked in that model.

// File: rtl/memq_pkg.sv
package memq_pkg;

   // Per-entry status bits of the queue
   typedef struct packed {
      logic vld;    // entry holds an operation
      logic st;     // 1 = store, 0 = load
      logic a_ok;   // address known
      logic d_ok;   // store data known
      logic done;   // load result produced
   } lsq_flags_t;

   // Outcome of one load search
   typedef enum logic [1:0] {
      SRCH_MEM  = 2'd0,
      SRCH_FWD  = 2'd1,
      SRCH_WAIT = 2'd2
   } srch_e;

endpackage

// File: rtl/memq_ring_ctl.sv
module memq_ring_ctl #(
   parameter int DEPTH = 8,
   localparam int IDXW = $clog2(DEPTH),
   localparam int CNTW = IDXW + 1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            alloc_vld_i,
   input  logic            retire_i,
   input  logic            flush_i,
   output logic            alloc_fire_o,
   output logic            full_o,
   output logic [IDXW-1:0] head_o,
   output logic [IDXW-1:0] tail_o
);

   localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

   logic [IDXW-1:0] head_q, tail_q, head_n;
   logic [CNTW-1:0] cnt_q;

   assign full_o       = (cnt_q == CNT_FULL);
   assign alloc_fire_o = alloc_vld_i && !full_o && !flush_i;
   assign head_n       = head_q + IDXW'(retire_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else if (flush_i) begin
         head_q <= head_n;
         tail_q <= head_n;
         cnt_q  <= '0;
      end else begin
         head_q <= head_n;
         tail_q <= tail_q + IDXW'(alloc_fire_o);
         cnt_q  <= cnt_q + CNTW'(alloc_fire_o) - CNTW'(retire_i);
      end
   end

   assign head_o = head_q;
   assign tail_o = tail_q;

endmodule

// File: rtl/memq_entry_file.sv
module memq_entry_file
   import memq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 8,
   parameter int DW    = 16,
   localparam int IDXW = $clog2(DEPTH)
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      alloc_fire_i,
   input  logic                      alloc_st_i,
   input  logic [IDXW-1:0]           tail_i,
   input  logic                      agu_vld_i,
   input  logic [IDXW-1:0]           agu_idx_i,
   input  logic [AW-1:0]             agu_addr_i,
   input  logic                      std_vld_i,
   input  logic [IDXW-1:0]           std_idx_i,
   input  logic [DW-1:0]             std_data_i,
   input  logic                      ldw_en_i,
   input  logic [IDXW-1:0]           ldw_idx_i,
   input  logic [DW-1:0]             ldw_data_i,
   input  logic                      retire_i,
   input  logic [IDXW-1:0]           head_i,
   input  logic                      flush_i,
   output lsq_flags_t [DEPTH-1:0]    view_flags_o,
   output logic [DEPTH-1:0][AW-1:0]  view_addr_o,
   output logic [DEPTH-1:0][DW-1:0]  view_data_o
);

   lsq_flags_t [DEPTH-1:0]   flags_q;
   logic [DEPTH-1:0][AW-1:0] addr_q;
   logic [DEPTH-1:0][DW-1:0] data_q;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      localparam logic [IDXW-1:0] MY = IDXW'(gi);

      lsq_flags_t      fl_v, fl_n;
      logic [AW-1:0]   ad_v;
      logic [DW-1:0]   dt_v, dt_n;

      // Same-cycle updates merged in front of the stored state
      always_comb begin
         fl_v = flags_q[gi];
         ad_v = addr_q[gi];
         dt_v = data_q[gi];
         if (agu_vld_i && agu_idx_i == MY && flags_q[gi].vld) begin
            fl_v.a_ok = 1'b1;
            ad_v      = agu_addr_i;
         end
         if (std_vld_i && std_idx_i == MY && flags_q[gi].vld && flags_q[gi].st) begin
            fl_v.d_ok = 1'b1;
            dt_v      = std_data_i;
         end
      end

      // Next state built on top of the merged view
      always_comb begin
         fl_n = fl_v;
         dt_n = dt_v;
         if (ldw_en_i && ldw_idx_i == MY) begin
            fl_n.done = 1'b1;
            dt_n      = ldw_data_i;
         end
         if (retire_i && head_i == MY) begin
            fl_n.vld = 1'b0;
         end
         if (alloc_fire_i && tail_i == MY) begin
            fl_n = '{vld: 1'b1, st: alloc_st_i, a_ok: 1'b0, d_ok: 1'b0, done: 1'b0};
         end
         if (flush_i) begin
            fl_n.vld = 1'b0;
         end
      end

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            flags_q[gi] <= '0;
            addr_q[gi]  <= '0;
            data_q[gi]  <= '0;
         end else begin
            flags_q[gi] <= fl_n;
            addr_q[gi]  <= ad_v;
            data_q[gi]  <= dt_n;
         end
      end

      assign view_flags_o[gi] = fl_v;
      assign view_addr_o[gi]  = ad_v;
      assign view_data_o[gi]  = dt_v;
   end

endmodule

// File: rtl/memq_fwd_search.sv
module memq_fwd_search
   import memq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int AW     = 8,
   parameter bit FWD_EN = 1'b1,
   localparam int IDXW  = $clog2(DEPTH)
) (
   input  logic [IDXW-1:0]          head_i,
   input  logic [IDXW-1:0]          ld_idx_i,
   input  lsq_flags_t [DEPTH-1:0]   flags_i,
   input  logic [DEPTH-1:0][AW-1:0] addr_i,
   output srch_e                    outcome_o,
   output logic [IDXW-1:0]          src_idx_o
);

   logic [IDXW-1:0] ld_age;
   logic [AW-1:0]   ld_addr;
   logic            pend_any, match_any, best_d_ok, fwd_ok;
   logic [IDXW-1:0] best_idx;

   assign ld_age  = ld_idx_i - head_i;
   assign ld_addr = addr_i[ld_idx_i];

   // Walk from oldest to youngest; a later match overrides, so the
   // surviving match is the one nearest the load in program order.
   always_comb begin
      pend_any  = 1'b0;
      match_any = 1'b0;
      best_d_ok = 1'b0;
      best_idx  = '0;
      for (int k = 0; k < DEPTH; k++) begin
         logic [IDXW-1:0] slot;
         slot = head_i + IDXW'(k);
         if (IDXW'(k) < ld_age && flags_i[slot].vld && flags_i[slot].st) begin
            if (!flags_i[slot].a_ok) begin
               pend_any = 1'b1;
            end else if (addr_i[slot] == ld_addr) begin
               match_any = 1'b1;
               best_idx  = slot;
               best_d_ok = flags_i[slot].d_ok;
            end
         end
      end
   end

   if (FWD_EN) begin : g_fwd
      assign fwd_ok = best_d_ok;
   end else begin : g_nofwd
      assign fwd_ok = 1'b0;
   end

   always_comb begin
      if (pend_any)                outcome_o = SRCH_WAIT;
      else if (match_any && fwd_ok) outcome_o = SRCH_FWD;
      else if (match_any)          outcome_o = SRCH_WAIT;
      else                         outcome_o = SRCH_MEM;
   end

   assign src_idx_o = best_idx;

endmodule

// File: rtl/memq_lsq.sv
module memq_lsq
   import memq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int AW     = 8,
   parameter int DW     = 16,
   parameter bit FWD_EN = 1'b1,
   localparam int IDXW  = $clog2(DEPTH)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            alloc_vld_i,
   input  logic            alloc_st_i,
   output logic            alloc_rdy_o,
   output logic [IDXW-1:0] alloc_idx_o,
   input  logic            agu_vld_i,
   input  logic [IDXW-1:0] agu_idx_i,
   input  logic [AW-1:0]   agu_addr_i,
   input  logic            std_vld_i,
   input  logic [IDXW-1:0] std_idx_i,
   input  logic [DW-1:0]   std_data_i,
   input  logic            ld_req_i,
   input  logic [IDXW-1:0] ld_idx_i,
   output logic [AW-1:0]   mem_raddr_o,
   input  logic [DW-1:0]   mem_rdata_i,
   output logic            res_vld_o,
   output logic [IDXW-1:0] res_idx_o,
   output logic [DW-1:0]   res_data_o,
   output logic            res_fwd_o,
   output logic            res_stall_o,
   input  logic            commit_i,
   output logic            retire_o,
   output logic            mem_we_o,
   output logic [AW-1:0]   mem_waddr_o,
   output logic [DW-1:0]   mem_wdata_o,
   input  logic            flush_i
);

   // Elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("memq_lsq: DEPTH must be a power of two of at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("memq_lsq: AW and DW must be positive");
   end

   logic                     alloc_fire, full;
   logic [IDXW-1:0]          head, tail;
   lsq_flags_t [DEPTH-1:0]   vflags;
   logic [DEPTH-1:0][AW-1:0] vaddr;
   logic [DEPTH-1:0][DW-1:0] vdata;
   srch_e                    outcome;
   logic [IDXW-1:0]          src_idx;
   lsq_flags_t               ldf, hdf;
   logic                     req_ok, ld_fin, head_ready;
   logic [DW-1:0]            ld_val;

   memq_ring_ctl #(.DEPTH(DEPTH)) ring_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_vld_i  (alloc_vld_i),
      .retire_i     (retire_o),
      .flush_i      (flush_i),
      .alloc_fire_o (alloc_fire),
      .full_o       (full),
      .head_o       (head),
      .tail_o       (tail)
   );

   memq_entry_file #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) ents_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_fire_i (alloc_fire),
      .alloc_st_i   (alloc_st_i),
      .tail_i       (tail),
      .agu_vld_i    (agu_vld_i),
      .agu_idx_i    (agu_idx_i),
      .agu_addr_i   (agu_addr_i),
      .std_vld_i    (std_vld_i),
      .std_idx_i    (std_idx_i),
      .std_data_i   (std_data_i),
      .ldw_en_i     (ld_fin),
      .ldw_idx_i    (ld_idx_i),
      .ldw_data_i   (ld_val),
      .retire_i     (retire_o),
      .head_i       (head),
      .flush_i      (flush_i),
      .view_flags_o (vflags),
      .view_addr_o  (vaddr),
      .view_data_o  (vdata)
   );

   memq_fwd_search #(.DEPTH(DEPTH), .AW(AW), .FWD_EN(FWD_EN)) srch_i (
      .head_i    (head),
      .ld_idx_i  (ld_idx_i),
      .flags_i   (vflags),
      .addr_i    (vaddr),
      .outcome_o (outcome),
      .src_idx_o (src_idx)
   );

   // Load request qualification and result selection
   assign ldf         = vflags[ld_idx_i];
   assign req_ok      = ld_req_i && ldf.vld && !ldf.st && ldf.a_ok && !ldf.done;
   assign ld_fin      = req_ok && (outcome != SRCH_WAIT) && !flush_i;
   assign ld_val      = (outcome == SRCH_FWD) ? vdata[src_idx] : mem_rdata_i;
   assign mem_raddr_o = vaddr[ld_idx_i];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         res_vld_o   <= 1'b0;
         res_stall_o <= 1'b0;
         res_fwd_o   <= 1'b0;
         res_idx_o   <= '0;
         res_data_o  <= '0;
      end else begin
         res_vld_o   <= ld_fin;
         res_stall_o <= req_ok && (outcome == SRCH_WAIT) && !flush_i;
         res_fwd_o   <= ld_fin && (outcome == SRCH_FWD);
         res_idx_o   <= ld_idx_i;
         res_data_o  <= ld_val;
      end
   end

   // Retirement from the head
   assign hdf         = vflags[head];
   assign head_ready  = hdf.vld && (hdf.st ? (hdf.a_ok && hdf.d_ok) : hdf.done);
   assign retire_o    = commit_i && head_ready;
   assign mem_we_o    = retire_o && hdf.st;
   assign mem_waddr_o = vaddr[head];
   assign mem_wdata_o = vdata[head];

   assign alloc_rdy_o = !full;
   assign alloc_idx_o = tail;

endmodule

// File: rtl/memq_lsq_chk.sv
module memq_lsq_chk #(
   parameter int DEPTH = 8,
   localparam int IDXW = $clog2(DEPTH)
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            alloc_rdy_o,
   input logic [IDXW-1:0] alloc_idx_o,
   input logic            flush_i,
   input logic            ld_req_i,
   input logic            res_vld_o,
   input logic            res_stall_o,
   input logic            commit_i,
   input logic            retire_o,
   input logic            mem_we_o
);

   // R10
   st_write_at_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_o |-> retire_o);

   // R11
   retire_needs_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      retire_o |-> commit_i);

   // R5
   res_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(res_vld_o && res_stall_o));

   // R3
   res_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_vld_o || res_stall_o) |-> $past(ld_req_i));

   // R12
   flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> alloc_rdy_o);

   // R12
   flush_drops_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (!res_vld_o && !res_stall_o));

   // R2
   full_holds_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!alloc_rdy_o && !flush_i) |=> $stable(alloc_idx_o));

endmodule

bind memq_lsq memq_lsq_chk #(.DEPTH(DEPTH)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .alloc_rdy_o (alloc_rdy_o),
   .alloc_idx_o (alloc_idx_o),
   .flush_i     (flush_i),
   .ld_req_i    (ld_req_i),
   .res_vld_o   (res_vld_o),
   .res_stall_o (res_stall_o),
   .commit_i    (commit_i),
   .retire_o    (retire_o),
   .mem_we_o    (mem_we_o)
);

// File: tb/memq_lsq_tb_top.sv
module memq_lsq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam int AW    = 8;
   localparam int DW    = 16;
   localparam int IDXW  = $clog2(DEPTH);

   logic            clk_i = 1'b0;
   logic            rst_ni = 1'b0;
   logic            alloc_vld_i = 1'b0, alloc_st_i = 1'b0;
   logic            alloc_rdy_o;
   logic [IDXW-1:0] alloc_idx_o;
   logic            agu_vld_i = 1'b0;
   logic [IDXW-1:0] agu_idx_i = '0;
   logic [AW-1:0]   agu_addr_i = '0;
   logic            std_vld_i = 1'b0;
   logic [IDXW-1:0] std_idx_i = '0;
   logic [DW-1:0]   std_data_i = '0;
   logic            ld_req_i = 1'b0;
   logic [IDXW-1:0] ld_idx_i = '0;
   logic [AW-1:0]   mem_raddr_o;
   logic [DW-1:0]   mem_rdata_i;
   logic            res_vld_o, res_fwd_o, res_stall_o;
   logic [IDXW-1:0] res_idx_o;
   logic [DW-1:0]   res_data_o;
   logic            commit_i = 1'b0, retire_o, mem_we_o;
   logic [AW-1:0]   mem_waddr_o;
   logic [DW-1:0]   mem_wdata_o;
   logic            flush_i = 1'b0;

   logic [DW-1:0]   mem [2**AW];
   int              n_chk = 0, n_bad = 0;
   bit              ended = 1'b0;

   always #(CLK_PERIOD / 2) clk_i = ~clk_i;

   assign mem_rdata_i = mem[mem_raddr_o];
   always @(posedge clk_i) if (mem_we_o) mem[mem_waddr_o] <= mem_wdata_o;

   memq_lsq #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (.*);

   function automatic logic [DW-1:0] init_val(input int a);
      return DW'(16'h1000 + a);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk_i);
      @(negedge clk_i);
   endtask

   task automatic do_reset();
      @(negedge clk_i);
      rst_ni = 1'b0;
      repeat (2) tick();
      rst_ni = 1'b1;
   endtask

   task automatic do_alloc(input logic st, output logic [IDXW-1:0] idx);
      alloc_vld_i = 1'b1; alloc_st_i = st;
      #1 idx = alloc_idx_o;
      tick();
      alloc_vld_i = 1'b0;
   endtask

   task automatic set_addr(input logic [IDXW-1:0] idx, input logic [AW-1:0] a);
      agu_vld_i = 1'b1; agu_idx_i = idx; agu_addr_i = a;
      tick();
      agu_vld_i = 1'b0;
   endtask

   task automatic set_data(input logic [IDXW-1:0] idx, input logic [DW-1:0] d);
      std_vld_i = 1'b1; std_idx_i = idx; std_data_i = d;
      tick();
      std_vld_i = 1'b0;
   endtask

   task automatic do_load(input logic [IDXW-1:0] idx);
      ld_req_i = 1'b1; ld_idx_i = idx;
      tick();
      ld_req_i = 1'b0;
   endtask

   task automatic do_commit(output logic r, output logic we,
                            output logic [AW-1:0] wa, output logic [DW-1:0] wd);
      commit_i = 1'b1;
      #1 begin r = retire_o; we = mem_we_o; wa = mem_waddr_o; wd = mem_wdata_o; end
      tick();
      commit_i = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 alloc_rdy", 32'(alloc_rdy_o), 1);
      chk("R1 alloc_idx", 32'(alloc_idx_o), 0);
      chk("R1 res_vld", 32'(res_vld_o), 0);
      chk("R1 res_stall", 32'(res_stall_o), 0);
      chk("R1 retire", 32'(retire_o), 0);
      chk("R1 mem_we", 32'(mem_we_o), 0);
   endtask

   task automatic t_plain();
      logic [IDXW-1:0] s0, l1;
      do_reset();
      do_alloc(1'b1, s0); do_alloc(1'b0, l1);
      set_addr(s0, 8'h11); set_data(s0, 16'hBEEF);
      set_addr(l1, 8'h10);
      do_load(l1);
      chk("R3 res_vld", 32'(res_vld_o), 1);
      chk("R3 res_idx", 32'(res_idx_o), 32'(l1));
      chk("R3 res_data", 32'(res_data_o), 32'(init_val(8'h10)));
      chk("R3 res_fwd", 32'(res_fwd_o), 0);
   endtask

   task automatic t_fwd();
      logic [IDXW-1:0] s0, s1, l2;
      do_reset();
      do_alloc(1'b1, s0); do_alloc(1'b1, s1); do_alloc(1'b0, l2);
      set_addr(s0, 8'h20); set_data(s0, 16'hAAAA);
      set_addr(s1, 8'h20); set_data(s1, 16'hBBBB);
      set_addr(l2, 8'h20);
      do_load(l2);
      chk("R4 res_vld", 32'(res_vld_o), 1);
      chk("R4 res_fwd", 32'(res_fwd_o), 1);
      chk("R4 youngest data", 32'(res_data_o), 32'hBBBB);
   endtask

   task automatic t_stall();
      logic [IDXW-1:0] s0, l1;
      do_reset();
      do_alloc(1'b1, s0); do_alloc(1'b0, l1);
      set_addr(l1, 8'h40);
      do_load(l1);
      chk("R5 res_stall", 32'(res_stall_o), 1);
      chk("R5 res_vld", 32'(res_vld_o), 0);
      set_addr(s0, 8'h41); set_data(s0, 16'h4141);
      do_load(l1);
      chk("R5 retry res_vld", 32'(res_vld_o), 1);
      chk("R5 retry data", 32'(res_data_o), 32'(init_val(8'h40)));
      // R6: matching store without data
      do_reset();
      do_alloc(1'b1, s0); do_alloc(1'b0, l1);
      set_addr(s0, 8'h42); set_addr(l1, 8'h42);
      do_load(l1);
      chk("R6 res_stall", 32'(res_stall_o), 1);
      set_data(s0, 16'h1234);
      do_load(l1);
      chk("R6 fwd after data", 32'(res_data_o), 32'h1234);
      chk("R6 res_fwd", 32'(res_fwd_o), 1);
   endtask

   task automatic t_young();
      logic [IDXW-1:0] l0, s1;
      do_reset();
      do_alloc(1'b0, l0); do_alloc(1'b1, s1);
      set_addr(l0, 8'h50); set_addr(s1, 8'h50); set_data(s1, 16'h7777);
      do_load(l0);
      chk("R7 res_vld", 32'(res_vld_o), 1);
      chk("R7 res_fwd", 32'(res_fwd_o), 0);
      chk("R7 res_data", 32'(res_data_o), 32'(init_val(8'h50)));
   endtask

   task automatic t_wrap();
      logic [IDXW-1:0] ix, s6, s7, s0, l1, l2;
      logic r, we; logic [AW-1:0] wa; logic [DW-1:0] wd;
      do_reset();
      for (int i = 0; i < 6; i++) begin
         do_alloc(1'b0, ix);
         set_addr(ix, AW'(8'hA0 + i));
         do_load(ix);
         do_commit(r, we, wa, wd);
         chk("R11 load retire", 32'(r), 1);
      end
      do_alloc(1'b1, s6); do_alloc(1'b1, s7); do_alloc(1'b1, s0);
      do_alloc(1'b0, l1); do_alloc(1'b0, l2);
      chk("R2 R8 wrap idx a", 32'(s6), 6);
      chk("R2 R8 wrap idx b", 32'(s0), 0);
      chk("R2 R8 wrap idx c", 32'(l2), 2);
      set_addr(s6, 8'h60); set_data(s6, 16'hC0DE);
      set_addr(s7, 8'h60); set_data(s7, 16'hD00D);
      set_addr(s0, 8'h61); set_data(s0, 16'h0001);
      set_addr(l1, 8'h60); set_addr(l2, 8'h61);
      do_load(l1);
      chk("R8 fwd across wrap", 32'(res_data_o), 32'hD00D);
      do_load(l2);
      chk("R8 fwd from slot 0", 32'(res_data_o), 32'h0001);
      chk("R8 res_fwd", 32'(res_fwd_o), 1);
   endtask

   task automatic t_same_cycle();
      logic [IDXW-1:0] s0, l1;
      do_reset();
      do_alloc(1'b1, s0); do_alloc(1'b0, l1);
      set_addr(l1, 8'h70);
      agu_vld_i = 1'b1; agu_idx_i = s0; agu_addr_i = 8'h70;
      std_vld_i = 1'b1; std_idx_i = s0; std_data_i = 16'h5151;
      ld_req_i = 1'b1; ld_idx_i = l1;
      tick();
      agu_vld_i = 1'b0; std_vld_i = 1'b0; ld_req_i = 1'b0;
      chk("R9 res_vld", 32'(res_vld_o), 1);
      chk("R9 fwd data", 32'(res_data_o), 32'h5151);
   endtask

   task automatic t_ignore();
      logic [IDXW-1:0] l0, s1;
      do_reset();
      do_load(3'd5);
      chk("R13 free entry", 32'({res_vld_o, res_stall_o}), 0);
      do_alloc(1'b0, l0); do_alloc(1'b1, s1);
      do_load(l0);
      chk("R13 no address", 32'({res_vld_o, res_stall_o}), 0);
      set_addr(s1, 8'h33);
      do_load(s1);
      chk("R13 store index", 32'({res_vld_o, res_stall_o}), 0);
      set_addr(l0, 8'h32);
      do_load(l0);
      chk("R13 first load ok", 32'(res_vld_o), 1);
      do_load(l0);
      chk("R13 done load", 32'({res_vld_o, res_stall_o}), 0);
   endtask

   task automatic t_full();
      logic [IDXW-1:0] ix;
      logic r, we; logic [AW-1:0] wa; logic [DW-1:0] wd;
      do_reset();
      for (int i = 0; i < DEPTH; i++) begin
         do_alloc(1'b1, ix);
         set_addr(ix, AW'(8'hC0 + i)); set_data(ix, DW'(16'h0C00 + i));
      end
      chk("R2 full rdy", 32'(alloc_rdy_o), 0);
      do_alloc(1'b1, ix);
      chk("R2 full idx held", 32'(alloc_idx_o), 0);
      do_commit(r, we, wa, wd);
      chk("R10 full commit we", 32'(we), 1);
      chk("R2 rdy after retire", 32'(alloc_rdy_o), 1);
      chk("R2 idx after drop", 32'(alloc_idx_o), 0);
   endtask

   task automatic t_commit();
      logic [IDXW-1:0] s0, l1;
      logic r, we; logic [AW-1:0] wa; logic [DW-1:0] wd;
      do_reset();
      do_alloc(1'b1, s0); do_alloc(1'b0, l1);
      set_addr(s0, 8'h80);
      do_commit(r, we, wa, wd);
      chk("R11 store no data retire", 32'(r), 0);
      chk("R10 no early write", 32'(we), 0);
      set_data(s0, 16'h9999);
      chk("R10 mem before commit", 32'(mem[8'h80]), 32'(init_val(8'h80)));
      do_commit(r, we, wa, wd);
      chk("R11 store retire", 32'(r), 1);
      chk("R10 we", 32'(we), 1);
      chk("R10 waddr", 32'(wa), 32'h80);
      chk("R10 wdata", 32'(wd), 32'h9999);
      chk("R10 mem after commit", 32'(mem[8'h80]), 32'h9999);
      do_commit(r, we, wa, wd);
      chk("R11 load not done", 32'(r), 0);
   endtask

   task automatic t_flush();
      logic [IDXW-1:0] s0, s1, l2;
      logic r, we; logic [AW-1:0] wa; logic [DW-1:0] wd;
      do_reset();
      do_alloc(1'b1, s0); do_alloc(1'b1, s1); do_alloc(1'b0, l2);
      set_addr(s0, 8'h90); set_data(s0, 16'h1111);
      set_addr(s1, 8'h91); set_data(s1, 16'h2222);
      set_addr(l2, 8'h92);
      flush_i = 1'b1;
      do_commit(r, we, wa, wd);
      flush_i = 1'b0;
      chk("R12 retire with flush", 32'(r), 1);
      chk("R12 write with flush", 32'(we), 1);
      chk("R12 rdy", 32'(alloc_rdy_o), 1);
      chk("R12 next idx", 32'(alloc_idx_o), 1);
      do_load(l2);
      chk("R12 flushed load", 32'({res_vld_o, res_stall_o}), 0);
      do_commit(r, we, wa, wd);
      chk("R12 empty commit", 32'(r), 0);
      chk("R12 retired store mem", 32'(mem[8'h90]), 32'h1111);
      chk("R12 flushed store mem", 32'(mem[8'h91]), 32'(init_val(8'h91)));
   endtask

   initial begin
      for (int a = 0; a < 2**AW; a++) mem[a] = init_val(a);
      t_reset();
      t_plain();
      t_fwd();
      t_stall();
      t_young();
      t_wrap();
      t_same_cycle();
      t_ignore();
      t_full();
      t_commit();
      t_flush();
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      if (!ended) begin
         ended = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule